// File: doc/BRIEF.md
# Inline Crypto Keyslot Register File

This block is the register file that sits in front of a storage host controller's inline encryption engine. Software sees it through a simple 32-bit register bus. It holds three things: a read-only capabilities word, a read-only table of per-algorithm capability entries, and a writable array of keyslots. Each keyslot carries sixteen key dwords, a control dword and one extra configuration dword.

The cipher datapath never reads the bus. It uses a registered lookup port instead: it presents a slot number and, one cycle later, receives the slot's valid flag, capability index, data-unit-size mask and key material. Key material goes out only through this port. Bus reads of key dwords always return zero.

A slot is programmed in a fixed order. Software clears the enable bit, writes the key and the extra dword, and writes the control dword with the enable bit set last. The slot is active only while that bit is set.

Top module: `kslot_regfile`

## Requirements
- R1: The byte address 0x000 reads the capabilities word. Bits [7:0] hold the capability entry count NUM_CAPS. Bits [15:8] hold NUM_SLOTS minus one. Bits [23:16] hold the configuration array pointer CFG_PTR. Bits [31:24] read zero.
- R2: The capability entry i (i < NUM_CAPS) reads at byte address 0x100 + 4*i. Its value has algorithm id i in bits [23:16], key size code i+1 in bits [15:8], and data-unit mask (0x08 | (1<<i)) in bits [7:0], where each mask bit stands for a multiple of 512 bytes. Bits [31:24] read zero.
- R3: Keyslot s starts at byte address CFG_PTR*0x100 + 128*s, with dword d at byte offset 4*d. Dword 16 is the control dword: enable in bit 31, capability index in [15:8], data-unit mask in [7:0]. Dwords 16 and 17 read back exactly as written.
- R4: A bus read of any key dword (dwords 0 to 15) of any keyslot returns zero.
- R5: The lookup valid output is 1 only when the presented slot's enable bit is set. The lookup outputs are registered, so values appear the cycle after the slot number is presented. A write that changes an enable bit is seen by the lookup on the following cycle.
- R6: For a valid slot, the low key output holds dwords 0 to 7 and the high key output holds dwords 8 to 15, with the lower dword in the lower bits. This places the second half of a split (XTS-style) key at the midpoint of the key field. While the valid output is 0, the capability index, mask and both key outputs are zero.
- R7: The following read zero and ignore writes: unaligned addresses, dwords 18 to 31 of a slot, capability entries at or beyond NUM_CAPS, addresses past the last slot, and any other unmapped offset.
- R8: Synchronous reset clears every dword of every keyslot, including the enable bits, and clears the read data and lookup outputs.
- R9: Read data is registered. It updates the cycle after a read strobe and holds its value while no read is strobed.
- R10: A lookup slot number at or beyond NUM_SLOTS yields valid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| lk_slot | input | 8 | Lookup slot number |
| lk_valid | output | 1 | Selected slot is enabled |
| lk_cap_idx | output | 8 | Capability index of the selected slot |
| lk_du_mask | output | 8 | Data-unit-size mask of the selected slot |
| lk_key_lo | output | 256 | Key dwords 0 to 7 |
| lk_key_hi | output | 256 | Key dwords 8 to 15 |

## Verification
The assertions assume the bus strobes and the lookup slot number are settled before each rising edge. They also assume reset is held for at least one edge before any property is checked. No assumption is made about ordering: a write and a read may target the same address in one cycle, and the read returns the old value.

The stimulus drives every input on the falling edge. It walks the full programming sequence, rewrites keys of live slots and disables slots mid-stream. It also reaches unmapped and out-of-range addresses and slot numbers, so the invariants are exercised on both sides of each boundary.

// File: rtl/kslot_pkg.sv
package kslot_pkg;

    localparam int DWORD_W       = 32;
    localparam int KEY_DWORDS    = 16;
    localparam int CTRL_DWORD    = 16;
    localparam int EXTRA_DWORD   = 17;
    localparam int STRIDE_BYTES  = 128;
    localparam int CAP_BASE      = 256;
    localparam int PTR_UNIT      = 256;
    localparam int KEY_W         = KEY_DWORDS * DWORD_W;
    localparam int HALF_KEY_W    = KEY_W / 2;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_CCAP,
        RG_CAPARR,
        RG_SLOT
    } kslot_region_e;

    typedef struct packed {
        kslot_region_e region;
        logic [7:0]    slot;
        logic [4:0]    dword;
        logic [7:0]    cap;
    } kslot_dec_t;

    typedef struct packed {
        logic       en;
        logic [14:0] rsvd;
        logic [7:0] cap_idx;
        logic [7:0] du_mask;
    } kslot_ctrl_t;

    typedef struct packed {
        logic [7:0] rsvd;
        logic [7:0] alg;
        logic [7:0] key_size;
        logic [7:0] du_mask;
    } kslot_cap_t;

    function automatic kslot_cap_t cap_entry(input int idx);
        kslot_cap_t c;
        c.rsvd     = 8'h00;
        c.alg      = 8'(idx);
        c.key_size = 8'(idx + 1);
        c.du_mask  = 8'h08 | 8'(1 << idx);
        return c;
    endfunction

endpackage

// File: rtl/kslot_addr_dec.sv
module kslot_addr_dec
    import kslot_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_SLOTS = 4,
    parameter int NUM_CAPS  = 2,
    parameter int CFG_PTR   = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output kslot_dec_t        dec
);

    localparam logic [31:0] CAP_LO = 32'(CAP_BASE);
    localparam logic [31:0] CAP_HI = 32'(CAP_BASE + 4 * NUM_CAPS);
    localparam logic [31:0] CFG_LO = 32'(CFG_PTR * PTR_UNIT);
    localparam logic [31:0] CFG_HI = 32'(CFG_PTR * PTR_UNIT + NUM_SLOTS * STRIDE_BYTES);

    logic [31:0] a32;
    logic [31:0] cap_off;
    logic [31:0] cfg_off;

    assign a32     = {{(32-ADDR_W){1'b0}}, addr};
    assign cap_off = (a32 - CAP_LO) >> 2;
    assign cfg_off = (a32 - CFG_LO) >> 7;

    always_comb begin
        dec        = '0;
        dec.region = RG_NONE;
        if (a32[1:0] == 2'b00) begin
            if (a32 == 32'h0) begin
                dec.region = RG_CCAP;
            end else if (a32 >= CAP_LO && a32 < CAP_HI) begin
                dec.region = RG_CAPARR;
                dec.cap    = cap_off[7:0];
            end else if (a32 >= CFG_LO && a32 < CFG_HI) begin
                dec.region = RG_SLOT;
                dec.slot   = cfg_off[7:0];
                dec.dword  = a32[6:2];
            end
        end
    end

endmodule

// File: rtl/kslot_cap_regs.sv
module kslot_cap_regs
    import kslot_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int NUM_CAPS  = 2,
    parameter int CFG_PTR   = 4
) (
    input  kslot_dec_t   dec,
    output logic [31:0]  data
);

    localparam logic [31:0] CCAP_VAL =
        {8'h00, 8'(CFG_PTR), 8'(NUM_SLOTS - 1), 8'(NUM_CAPS)};

    logic [31:0] cap_tbl [NUM_CAPS];

    for (genvar g = 0; g < NUM_CAPS; g++) begin : g_cap
        assign cap_tbl[g] = cap_entry(g);
    end

    always_comb begin
        data = '0;
        if (dec.region == RG_CCAP) begin
            data = CCAP_VAL;
        end else if (dec.region == RG_CAPARR) begin
            for (int i = 0; i < NUM_CAPS; i++) begin
                if (dec.cap == 8'(i)) data = cap_tbl[i];
            end
        end
    end

endmodule

// File: rtl/kslot_entry.sv
module kslot_entry
    import kslot_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [4:0]         dword,
    input  logic [31:0]        wdata,
    output logic [31:0]        rd_data,
    output logic               en_o,
    output logic [7:0]         cap_idx_o,
    output logic [7:0]         du_mask_o,
    output logic [KEY_W-1:0]   key_o
);

    logic [31:0] key_q [KEY_DWORDS];
    kslot_ctrl_t ctrl_q;
    logic [31:0] extra_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < KEY_DWORDS; i++) key_q[i] <= '0;
            ctrl_q  <= '0;
            extra_q <= '0;
        end else if (wr_en) begin
            if (dword < 5'(KEY_DWORDS))       key_q[dword[3:0]] <= wdata;
            else if (dword == 5'(CTRL_DWORD)) ctrl_q  <= kslot_ctrl_t'(wdata);
            else if (dword == 5'(EXTRA_DWORD)) extra_q <= wdata;
        end
    end

    always_comb begin
        rd_data = '0;
        if (dword == 5'(CTRL_DWORD))       rd_data = ctrl_q;
        else if (dword == 5'(EXTRA_DWORD)) rd_data = extra_q;
    end

    assign en_o      = ctrl_q.en;
    assign cap_idx_o = ctrl_q.cap_idx;
    assign du_mask_o = ctrl_q.du_mask;

    for (genvar g = 0; g < KEY_DWORDS; g++) begin : g_flat
        assign key_o[g*DWORD_W +: DWORD_W] = key_q[g];
    end

    // R5: clearing the enable bit drops the slot at once
    p_disable_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dword == 5'(CTRL_DWORD) && !wdata[31]) |=> !en_o);

    // R3: a control write is stored exactly
    p_ctrl_store_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dword == 5'(CTRL_DWORD)) |=> (cap_idx_o == $past(wdata[15:8]) && du_mask_o == $past(wdata[7:0])));

endmodule

// File: rtl/kslot_regfile.sv
module kslot_regfile
    import kslot_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_SLOTS = 4,
    parameter int NUM_CAPS  = 2,
    parameter int CFG_PTR   = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [7:0]            lk_slot,
    output logic                  lk_valid,
    output logic [7:0]            lk_cap_idx,
    output logic [7:0]            lk_du_mask,
    output logic [HALF_KEY_W-1:0] lk_key_lo,
    output logic [HALF_KEY_W-1:0] lk_key_hi
);

    kslot_dec_t      dec;
    logic [31:0]     cap_data;
    logic [31:0]     slot_rd  [NUM_SLOTS];
    logic [7:0]      slot_cap [NUM_SLOTS];
    logic [7:0]      slot_du  [NUM_SLOTS];
    logic [KEY_W-1:0] slot_key [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] slot_en;

    kslot_addr_dec #(
        .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .NUM_CAPS(NUM_CAPS), .CFG_PTR(CFG_PTR)
    ) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    kslot_cap_regs #(
        .NUM_SLOTS(NUM_SLOTS), .NUM_CAPS(NUM_CAPS), .CFG_PTR(CFG_PTR)
    ) u_cap (
        .dec  (dec),
        .data (cap_data)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic sel_wr;
        assign sel_wr = bus_wr && dec.region == RG_SLOT && dec.slot == 8'(g);
        kslot_entry u_entry (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (sel_wr),
            .dword     (dec.dword),
            .wdata     (bus_wdata),
            .rd_data   (slot_rd[g]),
            .en_o      (slot_en[g]),
            .cap_idx_o (slot_cap[g]),
            .du_mask_o (slot_du[g]),
            .key_o     (slot_key[g])
        );
    end

    logic [31:0] rd_next;
    always_comb begin
        rd_next = cap_data;
        if (dec.region == RG_SLOT) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (dec.slot == 8'(i)) rd_next = slot_rd[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    logic             lk_v_n;
    logic [7:0]       lk_cap_n;
    logic [7:0]       lk_du_n;
    logic [KEY_W-1:0] lk_key_n;

    always_comb begin
        lk_v_n   = 1'b0;
        lk_cap_n = '0;
        lk_du_n  = '0;
        lk_key_n = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (lk_slot == 8'(i) && slot_en[i]) begin
                lk_v_n   = 1'b1;
                lk_cap_n = slot_cap[i];
                lk_du_n  = slot_du[i];
                lk_key_n = slot_key[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_valid   <= 1'b0;
            lk_cap_idx <= '0;
            lk_du_mask <= '0;
            lk_key_lo  <= '0;
            lk_key_hi  <= '0;
        end else begin
            lk_valid   <= lk_v_n;
            lk_cap_idx <= lk_cap_n;
            lk_du_mask <= lk_du_n;
            lk_key_lo  <= lk_key_n[HALF_KEY_W-1:0];
            lk_key_hi  <= lk_key_n[KEY_W-1:HALF_KEY_W];
        end
    end

    // R4: key dwords never come back on the bus
    p_key_hidden_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && dec.region == RG_SLOT && dec.dword < 5'(KEY_DWORDS)) |=> bus_rdata == '0);

    // R7: unmapped reads return zero
    p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && dec.region == RG_NONE) |=> bus_rdata == '0);

    // R7: unmapped writes leave every enable untouched
    p_unmapped_wr_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && dec.region == RG_NONE) |=> $stable(slot_en));

    // R9: read data holds without a strobe
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R10: out-of-range lookup is never valid
    p_lk_range_r10: assert property (@(posedge clk) disable iff (rst)
        (lk_slot >= 8'(NUM_SLOTS)) |=> !lk_valid);

    // R6: an invalid lookup exposes nothing
    p_lk_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (lk_key_lo == '0 && lk_key_hi == '0 && lk_cap_idx == '0));

endmodule

// File: tb/tb_kslot_regfile.sv
module tb_kslot_regfile;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int NC = 2;
    localparam int PTR = 4;
    localparam int BASE = PTR * 256;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [7:0]   lk_slot = '0;
    logic         lk_valid;
    logic [7:0]   lk_cap_idx;
    logic [7:0]   lk_du_mask;
    logic [255:0] lk_key_lo;
    logic [255:0] lk_key_hi;

    kslot_regfile dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lk_slot(lk_slot), .lk_valid(lk_valid), .lk_cap_idx(lk_cap_idx),
        .lk_du_mask(lk_du_mask), .lk_key_lo(lk_key_lo), .lk_key_hi(lk_key_hi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0]  mem [NS][18];
    logic [31:0]  e_rdata;
    logic         e_valid;
    logic [7:0]   e_cap, e_du;
    logic [255:0] e_lo, e_hi;
    string        rtag, ltag;
    int           n_checks = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a, output string tag);
        int ai = int'(a);
        tag = "R7";
        if (a[1:0] != 2'b00) return 32'h0;
        if (ai == 0) begin
            tag = "R1";
            return {8'h00, 8'(PTR), 8'(NS - 1), 8'(NC)};
        end
        if (ai >= 256 && ai < 256 + 4 * NC) begin
            int i = (ai - 256) / 4;
            tag = "R2";
            return {8'h00, 8'(i), 8'(i + 1), 8'h08 | 8'(1 << i)};
        end
        if (ai >= BASE && ai < BASE + 128 * NS) begin
            int s = (ai - BASE) / 128;
            int d = (ai / 4) % 32;
            if (d < 16) begin tag = "R4"; return 32'h0; end
            if (d < 18) begin tag = "R3"; return mem[s][d]; end
            return 32'h0;
        end
        return 32'h0;
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        int ai = int'(a);
        if (a[1:0] == 2'b00 && ai >= BASE && ai < BASE + 128 * NS) begin
            int s = (ai - BASE) / 128;
            int w = (ai / 4) % 32;
            if (w < 18) mem[s][w] = d;
        end
    endtask

    task automatic model_lookup(input logic [7:0] s);
        e_valid = 1'b0; e_cap = '0; e_du = '0; e_lo = '0; e_hi = '0;
        ltag = (int'(s) >= NS) ? "R10" : "R5";
        if (int'(s) < NS && mem[s][16][31]) begin
            e_valid = 1'b1;
            e_cap = mem[s][16][15:8];
            e_du  = mem[s][16][7:0];
            for (int k = 0; k < 8; k++) begin
                e_lo[k*32 +: 32] = mem[s][k];
                e_hi[k*32 +: 32] = mem[s][k+8];
            end
        end
    endtask

    task automatic compare();
        check(bus_rdata == e_rdata, rtag, "rdata", 256'(bus_rdata), 256'(e_rdata));
        check(lk_valid == e_valid, ltag, "lk_valid", 256'(lk_valid), 256'(e_valid));
        check(lk_cap_idx == e_cap && lk_du_mask == e_du, "R6", "lk_cfg",
              256'({lk_cap_idx, lk_du_mask}), 256'({e_cap, e_du}));
        check(lk_key_lo == e_lo, "R6", "lk_key_lo", lk_key_lo, e_lo);
        check(lk_key_hi == e_hi, "R6", "lk_key_hi", lk_key_hi, e_hi);
    endtask

    task automatic step(input bit wr, input bit rd, input logic [11:0] a,
                        input logic [31:0] d, input logic [7:0] s);
        string t;
        @(negedge clk);
        compare();
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; lk_slot = s;
        if (rd) e_rdata = model_read(a, t);
        else t = "R9";
        rtag = t;
        model_lookup(s);
        if (wr) model_write(a, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0;
        for (int s = 0; s < NS; s++) for (int w = 0; w < 18; w++) mem[s][w] = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8: everything cleared after reset
        e_rdata = '0; e_valid = 1'b0; e_cap = '0; e_du = '0; e_lo = '0; e_hi = '0;
        rtag = "R8"; ltag = "R8";
        compare();
    endtask

    function automatic logic [11:0] sa(input int s, input int d);
        return 12'(BASE + 128 * s + 4 * d);
    endfunction

    task automatic program_slot(input int s, input logic [7:0] cap, input logic [7:0] du, input logic [7:0] look);
        step(1, 0, sa(s, 16), 32'h0, look);
        for (int k = 0; k < 16; k++) step(1, 0, sa(s, k), 32'hA000_0000 + 32'(s * 256 + k * 7 + 1), look);
        step(1, 0, sa(s, 17), 32'h5A00_0000 + 32'(s), look);
        step(1, 0, sa(s, 16), {1'b1, 15'h0, cap, du}, look);
    endtask

    initial begin
        for (int s = 0; s < NS; s++) for (int w = 0; w < 18; w++) mem[s][w] = '0;
        e_rdata = '0; rtag = "R8"; ltag = "R8";
        e_valid = 1'b0; e_cap = '0; e_du = '0; e_lo = '0; e_hi = '0;
        do_reset();
        // R1, R2: capability reads; entry past NC is R7
        step(0, 1, 12'h000, 0, 0);
        step(0, 1, 12'h100, 0, 0);
        step(0, 1, 12'h104, 0, 0);
        step(0, 1, 12'h108, 0, 0);
        step(0, 0, 12'h000, 0, 0);          // R9 hold
        // R3, R5, R6: program slot 1 while looking at it
        program_slot(1, 8'h00, 8'h08, 8'd1);
        step(0, 0, 12'h000, 0, 1);
        step(0, 1, sa(1, 3), 0, 1);         // R4
        step(0, 1, sa(1, 15), 0, 1);        // R4
        step(0, 1, sa(1, 16), 0, 1);        // R3
        step(0, 1, sa(1, 17), 0, 1);        // R3
        step(0, 1, sa(1, 20), 0, 1);        // R7
        step(0, 1, sa(1, 16) + 12'd1, 0, 1); // R7 unaligned
        // R7: writes to unmapped places ignored
        step(1, 0, 12'h600, 32'hFFFF_FFFF, 1);
        step(1, 0, 12'h050, 32'hFFFF_FFFF, 1);
        step(1, 0, 12'h108, 32'hFFFF_FFFF, 1);
        step(1, 0, sa(1, 25), 32'hFFFF_FFFF, 1);
        step(0, 1, 12'h600, 0, 1);
        step(0, 1, 12'h108, 0, 1);
        // R10: out-of-range lookup
        step(0, 0, 0, 0, 8'd4);
        step(0, 0, 0, 0, 8'd200);
        // other slots, lookup walks
        program_slot(3, 8'h01, 8'h02, 8'd3);
        program_slot(0, 8'h00, 8'h01, 8'd1);
        for (int s = 0; s < 6; s++) step(0, 0, 0, 0, 8'(s));
        // R5: rewrite key while live, then disable
        step(1, 0, sa(3, 9), 32'hDEAD_BEEF, 3);
        step(1, 0, sa(3, 0), 32'h1234_5678, 3);
        step(1, 1, sa(3, 16), 32'h0000_0102, 3);
        step(0, 1, sa(3, 16), 0, 3);
        step(0, 0, 0, 0, 3);
        step(1, 0, sa(3, 16), 32'h8000_0102, 3);
        step(0, 0, 0, 0, 3);
        // clear entry with all-zero writes
        for (int k = 0; k < 18; k++) step(1, 0, sa(0, k), 32'h0, 0);
        step(0, 1, sa(0, 17), 0, 0);
        step(0, 0, 0, 0, 0);
        // R8: reset mid-run clears live slots
        do_reset();
        step(0, 1, sa(1, 16), 0, 1);
        step(0, 1, sa(3, 17), 0, 3);
        step(0, 0, 0, 0, 3);
        step(0, 0, 0, 0, 1);
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule